// File: doc/BRIEF.md
# Configurable LUT Logic Cell

This block models one programmable logic cell. Two 4-input lookup tables each compute an arbitrary function of their own four inputs. A third, 3-input table takes both of their results plus one extra input, so the cell can also build selected functions of up to nine inputs. Two combinational outputs each pick one of the three table results. Two storage elements each take their data from one of the table results or from a direct data input. The clock edge, the kind of asynchronous override (set or clear) and the use of the clock enable are chosen per element.

All configuration is held in one shift chain of 54 bits. It is loaded serially, most significant bit first, while `cfgEn` is high. The logic outputs are only meaningful once loading is complete. An active-low reset clears the chain and both storage elements.

Top module: `lutcell_top`

## Requirements
- R1: After reset, with all configuration bits zero, `x`, `y`, `xq` and `yq` are all 0.
- R2: On each rising clock edge with `cfgEn` high, the chain shifts one place toward its MSB and `cfgDin` enters at bit 0, so that after 54 shifts the first bit sent sits at bit 53. With `cfgEn` low the configuration does not change.
- R3: Table F' is chain bits [53:38] and G' is bits [37:22]. The output of each is the table bit indexed by its 4-bit input (`fIn` or `gIn`), with input bit 0 as the index LSB.
- R4: Table H' is chain bits [21:14], indexed by {`h1`, G', F'}, so F' is the index LSB.
- R5: `x` is selected by bits [13:12] and `y` by bits [11:10]. Code 0 selects F', 1 selects G', and 2 or 3 select H'.
- R6: The `xq` element is controlled by bits [9:5] and the `yq` element by bits [4:0]. Each 5-bit field is {dsel[1:0], falling, srSet, ecUse}. A dsel of 0, 1 or 2 takes F', G' or H', and 3 takes `din`.
- R7: With `falling` = 0 an element loads on the rising clock edge, and with `falling` = 1 it loads on the falling edge.
- R8: While `sr` is high, an element is forced at once to `srSet`, without waiting for a clock edge, and clock loads are blocked.
- R9: With `ecUse` = 1 an element loads only when `ec` is high. With `ecUse` = 0, `ec` has no effect.
- R10: Driving `rst_n` low at any time clears the chain and both elements at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgEn | input | 1 | Shift enable for the configuration chain |
| cfgDin | input | 1 | Serial configuration data, MSB first |
| fIn | input | 4 | Inputs of table F' |
| gIn | input | 4 | Inputs of table G' |
| h1 | input | 1 | Extra input of table H' |
| din | input | 1 | Direct data input for the storage elements |
| ec | input | 1 | Shared clock enable |
| sr | input | 1 | Shared asynchronous set/clear request |
| x | output | 1 | Combinational output X |
| y | output | 1 | Combinational output Y |
| xq | output | 1 | Registered output X |
| yq | output | 1 | Registered output Y |

## Verification
On every cycle the assertions check that the chain holds still when loading is off and shifts by exactly one place when it is on. They also check that a held `sr` pins each element to its configured override value, that reset leaves the chain and both elements at zero, and that `x` always carries one of the three table results. Which table bit is looked up, which source and which clock edge each element uses, and whether `ec` is honoured can only be shown by the bench. Its behavioural model replays two different configurations under random inputs and compares all four outputs after every clock edge of both polarities.

// File: rtl/lutcell_pkg.sv
package lutcell_pkg;
  localparam int LUT_IN   = 4;
  localparam int H_IN     = 3;
  localparam int LUT_BITS = 1 << LUT_IN;
  localparam int H_BITS   = 1 << H_IN;
  localparam int NUM_REGS = 2;
  localparam int REG_XQ   = 1;
  localparam int REG_YQ   = 0;

  typedef enum logic [1:0] {
    SRC_F   = 2'd0,
    SRC_G   = 2'd1,
    SRC_H   = 2'd2,
    SRC_ALT = 2'd3
  } src_e;

  typedef struct packed {
    src_e dSel;
    logic falling;
    logic srSet;
    logic ecUse;
  } regCtl_t;

  typedef struct packed {
    logic [LUT_BITS-1:0] lutF;
    logic [LUT_BITS-1:0] lutG;
    logic [H_BITS-1:0]   lutH;
    src_e                xSel;
    src_e                ySel;
    regCtl_t [NUM_REGS-1:0] regs;
  } cellCfg_t;

  localparam int CFG_W = $bits(cellCfg_t);
endpackage

// File: rtl/lutcell_cfgchain.sv
module lutcell_cfgchain
  import lutcell_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cfgEn,
  input  logic     cfgDin,
  output cellCfg_t cfg
);
  logic [CFG_W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else if (cfgEn) begin
      chain <= {chain[CFG_W-2:0], cfgDin};
    end
  end

  assign cfg = cellCfg_t'(chain);
endmodule

// File: rtl/lutcell_lut.sv
module lutcell_lut #(
  parameter int IN = 4
) (
  input  logic [(1<<IN)-1:0] truth,
  input  logic [IN-1:0]      sel,
  output logic               out
);
  assign out = truth[sel];
endmodule

// File: rtl/lutcell_reg.sv
module lutcell_reg
  import lutcell_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  regCtl_t ctl,
  input  logic    d,
  input  logic    ec,
  input  logic    sr,
  output logic    q
);
  logic qRise;
  logic qFall;
  logic loadOk;

  assign loadOk = !ctl.ecUse || ec;

  always_ff @(posedge clk or negedge rst_n or posedge sr) begin
    if (!rst_n) begin
      qRise <= 1'b0;
    end else if (sr) begin
      qRise <= ctl.srSet;
    end else if (loadOk) begin
      qRise <= d;
    end
  end

  always_ff @(negedge clk or negedge rst_n or posedge sr) begin
    if (!rst_n) begin
      qFall <= 1'b0;
    end else if (sr) begin
      qFall <= ctl.srSet;
    end else if (loadOk) begin
      qFall <= d;
    end
  end

  assign q = ctl.falling ? qFall : qRise;
endmodule

// File: rtl/lutcell_datapath.sv
module lutcell_datapath
  import lutcell_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  cellCfg_t            cfg,
  input  logic [LUT_IN-1:0]   fIn,
  input  logic [LUT_IN-1:0]   gIn,
  input  logic                h1,
  input  logic                din,
  input  logic                ec,
  input  logic                sr,
  output logic                fOut,
  output logic                gOut,
  output logic                hOut,
  output logic                x,
  output logic                y,
  output logic [NUM_REGS-1:0] q
);
  function automatic logic pick(src_e s, logic f, logic g, logic h, logic alt);
    case (s)
      SRC_F:   return f;
      SRC_G:   return g;
      SRC_H:   return h;
      default: return alt;
    endcase
  endfunction

  logic [H_IN-1:0] hIdx;

  lutcell_lut #(.IN(LUT_IN)) u_lutF (.truth(cfg.lutF), .sel(fIn),  .out(fOut));
  lutcell_lut #(.IN(LUT_IN)) u_lutG (.truth(cfg.lutG), .sel(gIn),  .out(gOut));

  assign hIdx = {h1, gOut, fOut};
  lutcell_lut #(.IN(H_IN))   u_lutH (.truth(cfg.lutH), .sel(hIdx), .out(hOut));

  always_comb begin
    x = pick(cfg.xSel, fOut, gOut, hOut, hOut);
    y = pick(cfg.ySel, fOut, gOut, hOut, hOut);
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic dVal;
    assign dVal = pick(cfg.regs[r].dSel, fOut, gOut, hOut, din);
    lutcell_reg u_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .ctl  (cfg.regs[r]),
      .d    (dVal),
      .ec   (ec),
      .sr   (sr),
      .q    (q[r])
    );
  end
endmodule

// File: rtl/lutcell_top.sv
module lutcell_top
  import lutcell_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgEn,
  input  logic              cfgDin,
  input  logic [LUT_IN-1:0] fIn,
  input  logic [LUT_IN-1:0] gIn,
  input  logic              h1,
  input  logic              din,
  input  logic              ec,
  input  logic              sr,
  output logic              x,
  output logic              y,
  output logic              xq,
  output logic              yq
);
  cellCfg_t            cfg;
  logic                fOut;
  logic                gOut;
  logic                hOut;
  logic [NUM_REGS-1:0] qAll;

  lutcell_cfgchain u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .cfgEn (cfgEn),
    .cfgDin(cfgDin),
    .cfg   (cfg)
  );

  lutcell_datapath u_dp (
    .clk  (clk),
    .rst_n(rst_n),
    .cfg  (cfg),
    .fIn  (fIn),
    .gIn  (gIn),
    .h1   (h1),
    .din  (din),
    .ec   (ec),
    .sr   (sr),
    .fOut (fOut),
    .gOut (gOut),
    .hOut (hOut),
    .x    (x),
    .y    (y),
    .q    (qAll)
  );

  assign xq = qAll[REG_XQ];
  assign yq = qAll[REG_YQ];
endmodule

// File: rtl/lutcell_check.sv
module lutcell_check
  import lutcell_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfgEn,
  input logic             cfgDin,
  input logic             sr,
  input logic             x,
  input logic             xq,
  input logic             yq,
  input logic             fOut,
  input logic             gOut,
  input logic             hOut,
  input logic [CFG_W-1:0] cfgBits
);
  cellCfg_t c;
  assign c = cellCfg_t'(cfgBits);

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgEn |=> $stable(cfgBits)); // R2

  AST_CFG_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    cfgEn |=> (cfgBits[CFG_W-1:1] == $past(cfgBits[CFG_W-2:0])) && (cfgBits[0] == $past(cfgDin))); // R2

  AST_XQ_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (sr && $past(sr) && !$past(cfgEn)) |-> (xq == c.regs[REG_XQ].srSet)); // R8

  AST_YQ_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (sr && $past(sr) && !$past(cfgEn)) |-> (yq == c.regs[REG_YQ].srSet)); // R8

  AST_X_FROM_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (x == fOut) || (x == gOut) || (x == hOut)); // R5

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (cfgBits == '0 && xq == 1'b0 && yq == 1'b0); // R10
    end
  end
endmodule

bind lutcell_top lutcell_check u_check (
  .clk    (clk),
  .rst_n  (rst_n),
  .cfgEn  (cfgEn),
  .cfgDin (cfgDin),
  .sr     (sr),
  .x      (x),
  .xq     (xq),
  .yq     (yq),
  .fOut   (fOut),
  .gOut   (gOut),
  .hOut   (hOut),
  .cfgBits(cfg)
);

// File: tb/test_lutcell_top.sv
module test_lutcell_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       cfgEn = 1'b0;
  logic       cfgDin = 1'b0;
  logic [3:0] fIn = '0;
  logic [3:0] gIn = '0;
  logic       h1 = 1'b0;
  logic       din = 1'b0;
  logic       ec = 1'b0;
  logic       sr = 1'b0;
  logic       x, y, xq, yq;

  lutcell_top i_lutcell_top (
    .clk(clk), .rst_n(rst_n), .cfgEn(cfgEn), .cfgDin(cfgDin),
    .fIn(fIn), .gIn(gIn), .h1(h1), .din(din), .ec(ec), .sr(sr),
    .x(x), .y(y), .xq(xq), .yq(yq)
  );

  always #5 clk = ~clk;

  int    tests = 0;
  int    fails = 0;
  bit    started = 0;
  bit    done = 0;
  string phase = "R1 R10 reset";

  // Behavioural model: chain contents, and for each element (1 = xq, 0 = yq)
  // a rising-edge and a falling-edge copy.
  logic [53:0] mcfg = '0;
  bit          mR[2];
  bit          mF[2];

  function automatic bit fv();  return mcfg[38 + int'(fIn)]; endfunction
  function automatic bit gv();  return mcfg[22 + int'(gIn)]; endfunction
  function automatic bit hv();  return mcfg[14 + int'({h1, gv(), fv()})]; endfunction
  function automatic bit srcv(logic [1:0] s, bit alt);
    if (s == 2'd0) return fv();
    if (s == 2'd1) return gv();
    if (s == 2'd2) return hv();
    return alt;
  endfunction
  function automatic int base(int r); return (r == 1) ? 5 : 0; endfunction
  function automatic logic [1:0] dsel(int r); return mcfg[base(r)+3 +: 2]; endfunction
  function automatic bit fall(int r);  return mcfg[base(r)+2]; endfunction
  function automatic bit srs(int r);   return mcfg[base(r)+1]; endfunction
  function automatic bit ecu(int r);   return mcfg[base(r)];   endfunction
  function automatic bit expX(); return srcv(mcfg[13:12], hv()); endfunction
  function automatic bit expY(); return srcv(mcfg[11:10], hv()); endfunction
  function automatic bit expQ(int r); return fall(r) ? mF[r] : mR[r]; endfunction

  function automatic bit nextQ(int r, bit cur);
    if (sr) return srs(r);
    if (!ecu(r) || ec) return srcv(dsel(r), din);
    return cur;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcfg = '0;
      for (int r = 0; r < 2; r++) begin mR[r] = 0; mF[r] = 0; end
    end else begin
      for (int r = 0; r < 2; r++) mR[r] = nextQ(r, mR[r]);
      if (cfgEn) mcfg = {mcfg[52:0], cfgDin};
    end
  end

  always @(negedge clk) begin
    if (rst_n) for (int r = 0; r < 2; r++) mF[r] = nextQ(r, mF[r]);
  end

  always @(posedge sr) begin
    if (rst_n) for (int r = 0; r < 2; r++) begin mR[r] = srs(r); mF[r] = srs(r); end
  end

  task automatic chk(string what, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", phase, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("x", x, expX());
    chk("y", y, expY());
    chk("xq", xq, expQ(1));
    chk("yq", yq, expQ(0));
  endtask

  always @(posedge clk) begin #4; if (started && !done) compareAll(); end
  always @(negedge clk) begin #4; if (started && !done) compareAll(); end

  task automatic randIns();
    fIn = 4'($urandom); gIn = 4'($urandom);
    h1 = 1'($urandom); din = 1'($urandom); ec = 1'($urandom);
  endtask

  task automatic load(logic [53:0] v);
    for (int i = 53; i >= 0; i--) begin
      if (i % 7 == 3) begin
        @(posedge clk); #2; cfgEn = 0; cfgDin = ~v[i]; randIns();  // R2 gap: bit must not enter
      end
      @(posedge clk); #2; cfgEn = 1; cfgDin = v[i]; randIns();
    end
    @(posedge clk); #2; cfgEn = 0;
  endtask

  function automatic logic [53:0] build(logic [15:0] f, logic [15:0] g, logic [7:0] h,
      logic [1:0] xs, logic [1:0] ys, logic [4:0] xc, logic [4:0] yc);
    return {f, g, h, xs, ys, xc, yc};
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic held;
    #1 rst_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    started = 1;
    #2;
    phase = "R1 reset state";
    chk("x", x, 0); chk("y", y, 0); chk("xq", xq, 0); chk("yq", yq, 0);

    // Config A: F=AND4, G=parity, H=F^G^h1, x<-H, y<-G,
    // xq: din, rising, set, ec used; yq: F', falling, clear, ec ignored
    phase = "R2 load A";
    load(build(16'h8000, 16'h6996, 8'h96, 2'd2, 2'd1, 5'b11_0_1_1, 5'b00_1_0_0));
    phase = "R3 R4 R5 R6 R7 R9 config A";
    repeat (60) begin @(posedge clk); #2; randIns(); end
    fIn = 4'hF; gIn = 4'h1; h1 = 0; #2;
    chk("R3 F' all ones via H'", x, 1'b0);   // F=1,G=1,h1=0 -> H'=0
    chk("R3 G' parity on y", y, 1'b1);

    phase = "R8 async sr config A";
    @(posedge clk); #2; sr = 1; #1;
    chk("R8 xq set", xq, 1'b1); chk("R8 yq clear", yq, 1'b0);
    repeat (2) begin @(posedge clk); #2; randIns(); end
    sr = 0;

    // Config B: F=OR4, G=16'hCAFE, H=majority, x<-F, y<-H (code 3),
    // xq: H', falling, clear, ec ignored; yq: G', rising, set, ec used
    phase = "R2 load B";
    load(build(16'hFFFE, 16'hCAFE, 8'hE8, 2'd0, 2'd3, 5'b10_1_0_0, 5'b01_0_1_1));
    phase = "R4 R5 R6 R7 R9 config B";
    repeat (60) begin @(posedge clk); #2; randIns(); end

    phase = "R8 async sr config B";
    @(posedge clk); #6; sr = 1; #1;
    chk("R8 xq clear", xq, 1'b0); chk("R8 yq set", yq, 1'b1);
    @(posedge clk); #2; sr = 0;

    phase = "R9 ec low holds yq";
    @(posedge clk); #2; ec = 0; #1; held = yq;
    repeat (3) begin @(posedge clk); #2; gIn = 4'($urandom); din = 1'($urandom); end
    #1 chk("R9 yq held", yq, held);

    phase = "R10 reset mid-run";
    @(posedge clk); #2; rst_n = 0; #1;
    chk("R10 x", x, 0); chk("R10 y", y, 0); chk("R10 xq", xq, 0); chk("R10 yq", yq, 0);
    @(posedge clk); #2; rst_n = 1;
    repeat (4) begin @(posedge clk); #2; randIns(); end
    summary();
  end
endmodule